// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit tests one bit of a 32-bit operand and can then set, clear or invert that bit. The operand is either a register value handed in with the command or a dword in memory. The bit position comes either from a 32-bit register offset or from an 8-bit immediate. The unit returns the updated value and a carry bit. The carry bit always holds the bit as it was before the operation.

For a memory operand the unit computes the dword address and reads the dword over a simple request/ready memory port. For a modifying operation it then writes the updated dword back to the same address. A register offset is signed. Its bits above the bit index select a dword relative to the base address, above it or below it. While a modifying memory operation is in progress, the unit raises a flag so that the surrounding system can keep the read and the write indivisible.

Commands arrive on a valid/ready handshake, and a command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is high only while the unit is idle. Results leave on a valid/ready handshake. `res_valid` stays high, with its value and carry held steady, until a cycle with `res_ready` high. No new command is taken until that result has been consumed.

Top module: `bit_modify_unit`

## Requirements
- R1: `res_cf` equals the selected bit of the operand as it was before any change.
- R2: The operation code `cmd_op` is decoded as follows: 0 tests the bit and leaves the operand unchanged, 1 forces the bit to 1, 2 forces the bit to 0, and 3 inverts it. The returned value `res_value` is the operand with only that change applied.
- R3: For a register operand (`cmd_mem`=0), the bit index is bits [4:0] of the offset. The offset is `cmd_imm8` when `cmd_imm`=1 and `cmd_offset` otherwise.
- R4: For a memory operand with a register offset (`cmd_mem`=1, `cmd_imm`=0), `cmd_offset` is treated as signed. `cmd_offset` arithmetically shifted right by 5, then times 4, is added to `cmd_ea`, and bits [4:0] of the offset select the bit.
- R5: For a memory operand with an immediate offset, only `cmd_imm8`[4:0] is used, and the address is `cmd_ea` without adjustment.
- R6: The memory address is ANDed with 0x0000FFFF when `cmd_wide`=0 and with 0xFFFFFFFF when `cmd_wide`=1.
- R7: A memory test performs exactly one read and no write. A memory set, clear or invert performs one read and then one write of the updated dword to the same address. The request, address and write enable hold steady until `mem_rdy`.
- R8: `mem_lock` is high from the read request until the write completes for modifying memory operations, and stays low for a memory test.
- R9: A register operation makes no memory request and raises `res_valid` in the cycle after it is accepted. `res_wr` is 1 for set, clear and invert on a register, and 0 for a register test and for every memory operation.
- R10: `cmd_ready` is high only while idle with no result pending. A result held by `res_ready`=0 keeps `res_valid`, `res_value` and `res_cf` steady.
- R11: After reset `cmd_ready`=1, and `res_valid`, `mem_req` and `mem_lock` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid is high |
| cmd_op | input | 2 | 0 test, 1 set, 2 clear, 3 invert |
| cmd_mem | input | 1 | 1 selects the memory operand |
| cmd_imm | input | 1 | 1 takes the offset from cmd_imm8 |
| cmd_wide | input | 1 | 1 for 32-bit addresses, 0 for a 16-bit mask |
| cmd_reg_val | input | 32 | Register operand |
| cmd_offset | input | 32 | Register bit offset, signed for memory |
| cmd_imm8 | input | 8 | Immediate bit offset |
| cmd_ea | input | 32 | Base effective address |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer ready |
| res_value | output | 32 | Updated operand value |
| res_cf | output | 1 | Original value of the selected bit |
| res_wr | output | 1 | Register write-back enable |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Dword byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rdy on a read |
| mem_rdy | input | 1 | Completes the current memory request |
| mem_lock | output | 1 | Atomic read-modify-write in progress |

## Verification
A wrong state in the sequencer shows at the ports within a few cycles. It shows as a missing or extra write, a read and a write at different addresses, a lock that drops between the read and the write, or a result valid that never rises or rises without a request behind it. A wrong bit index or displacement shows as a wrong address on the first memory request, or as a wrong value and carry on the very next result. Stalls of varying length on memory readiness and on the result consumer bring out hold errors on the memory request and on the result.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [1:0] {
    BMU_TEST = 2'd0,
    BMU_SET  = 2'd1,
    BMU_CLR  = 2'd2,
    BMU_FLIP = 2'd3
  } bmu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CALC  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } bmu_state_e;
endpackage

// File: rtl/bmu_locate.sv
// Bit index and dword address generation.
module bmu_locate #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int IMMW = 8,
  parameter int NARROW_BITS = 16,
  localparam int IW = $clog2(DW)
) (
  input  logic            use_imm,
  input  logic [DW-1:0]   roff,
  input  logic [IMMW-1:0] imm,
  input  logic [AW-1:0]   ea,
  input  logic            wide,
  output logic [IW-1:0]   idx,
  output logic [AW-1:0]   addr
);
  localparam int BSH = $clog2(DW / 8);
  localparam logic [AW-1:0] NARROW_MASK = {{(AW-NARROW_BITS){1'b0}}, {NARROW_BITS{1'b1}}};

  logic signed [DW-1:0] disp;
  logic [AW-1:0]        step;
  logic [AW-1:0]        base;
  logic                 unused_imm_hi;

  assign unused_imm_hi = ^imm[IMMW-1:IW];

  always_comb begin
    disp = $signed(roff) >>> IW;
    step = AW'(disp) << BSH;
    base = use_imm ? ea : (ea + step);
    addr = base & (wide ? {AW{1'b1}} : NARROW_MASK);
    idx  = use_imm ? imm[IW-1:0] : roff[IW-1:0];
  end
endmodule

// File: rtl/bmu_alter.sv
// Single-bit test and modify on one word.
module bmu_alter
  import bmu_pkg::*;
#(
  parameter int DW = 32,
  localparam int IW = $clog2(DW)
) (
  input  logic [DW-1:0] word,
  input  logic [IW-1:0] idx,
  input  bmu_op_e       op,
  output logic [DW-1:0] new_word,
  output logic          old_bit
);
  logic [DW-1:0] hit;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign hit[b] = (idx == IW'(b));
    always_comb begin
      new_word[b] = word[b];
      if (hit[b]) begin
        unique case (op)
          BMU_SET:  new_word[b] = 1'b1;
          BMU_CLR:  new_word[b] = 1'b0;
          BMU_FLIP: new_word[b] = ~word[b];
          default:  new_word[b] = word[b];
        endcase
      end
    end
  end

  assign old_bit = |(word & hit);
endmodule

// File: rtl/bmu_ctrl.sv
// Sequencer: command capture, memory phases, result holding.
module bmu_ctrl
  import bmu_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int IMMW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic            cmd_mem,
  input  logic            cmd_imm,
  input  logic            cmd_wide,
  input  logic [DW-1:0]   cmd_reg_val,
  input  logic [DW-1:0]   cmd_offset,
  input  logic [IMMW-1:0] cmd_imm8,
  input  logic [AW-1:0]   cmd_ea,
  output logic            loc_use_imm,
  output logic [DW-1:0]   loc_roff,
  output logic [IMMW-1:0] loc_imm,
  output logic [AW-1:0]   loc_ea,
  output logic            loc_wide,
  input  logic [IW-1:0]   loc_idx,
  input  logic [AW-1:0]   loc_addr,
  output logic [DW-1:0]   alt_word,
  output logic [IW-1:0]   alt_idx,
  output bmu_op_e         alt_op,
  input  logic [DW-1:0]   alt_new,
  input  logic            alt_old,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [DW-1:0]   res_value,
  output logic            res_cf,
  output logic            res_wr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_rdy,
  output logic            mem_lock
);
  bmu_state_e      state_q;
  bmu_op_e         op_q;
  logic            imm_q;
  logic            wide_q;
  logic [DW-1:0]   roff_q;
  logic [IMMW-1:0] imm8_q;
  logic [AW-1:0]   ea_q;
  logic [IW-1:0]   idx_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   val_q;
  logic            cf_q;
  logic            wr_q;
  logic            live;

  always_comb begin
    live        = (state_q == ST_IDLE);
    loc_use_imm = live ? cmd_imm    : imm_q;
    loc_roff    = live ? cmd_offset : roff_q;
    loc_imm     = live ? cmd_imm8   : imm8_q;
    loc_ea      = live ? cmd_ea     : ea_q;
    loc_wide    = live ? cmd_wide   : wide_q;
    alt_word    = live ? cmd_reg_val : mem_rdata;
    alt_idx     = live ? loc_idx : idx_q;
    alt_op      = live ? bmu_op_e'(cmd_op) : op_q;
    cmd_ready   = live;
    res_valid   = (state_q == ST_DONE);
    mem_req     = (state_q == ST_READ) || (state_q == ST_WRITE);
    mem_we      = (state_q == ST_WRITE);
    mem_addr    = addr_q;
    mem_wdata   = val_q;
    mem_lock    = mem_req && (op_q != BMU_TEST);
    res_value   = val_q;
    res_cf      = cf_q;
    res_wr      = wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= BMU_TEST;
      imm_q   <= 1'b0;
      wide_q  <= 1'b0;
      roff_q  <= '0;
      imm8_q  <= '0;
      ea_q    <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      val_q   <= '0;
      cf_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q   <= bmu_op_e'(cmd_op);
            imm_q  <= cmd_imm;
            wide_q <= cmd_wide;
            roff_q <= cmd_offset;
            imm8_q <= cmd_imm8;
            ea_q   <= cmd_ea;
            idx_q  <= loc_idx;
            if (cmd_mem) begin
              wr_q    <= 1'b0;
              state_q <= ST_CALC;
            end else begin
              val_q   <= alt_new;
              cf_q    <= alt_old;
              wr_q    <= (bmu_op_e'(cmd_op) != BMU_TEST);
              state_q <= ST_DONE;
            end
          end
        end
        ST_CALC: begin
          addr_q  <= loc_addr;
          state_q <= ST_READ;
        end
        ST_READ: begin
          if (mem_rdy) begin
            val_q   <= alt_new;
            cf_q    <= alt_old;
            state_q <= (op_q == BMU_TEST) ? ST_DONE : ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_rdy) state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (res_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
  import bmu_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int IMMW = 8,
  parameter int NARROW_BITS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic            cmd_mem,
  input  logic            cmd_imm,
  input  logic            cmd_wide,
  input  logic [DW-1:0]   cmd_reg_val,
  input  logic [DW-1:0]   cmd_offset,
  input  logic [IMMW-1:0] cmd_imm8,
  input  logic [AW-1:0]   cmd_ea,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [DW-1:0]   res_value,
  output logic            res_cf,
  output logic            res_wr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_rdy,
  output logic            mem_lock
);
  localparam int IW = $clog2(DW);

  logic            loc_use_imm;
  logic [DW-1:0]   loc_roff;
  logic [IMMW-1:0] loc_imm;
  logic [AW-1:0]   loc_ea;
  logic            loc_wide;
  logic [IW-1:0]   loc_idx;
  logic [AW-1:0]   loc_addr;
  logic [DW-1:0]   alt_word;
  logic [IW-1:0]   alt_idx;
  bmu_op_e         alt_op;
  logic [DW-1:0]   alt_new;
  logic            alt_old;

  bmu_locate #(.DW(DW), .AW(AW), .IMMW(IMMW), .NARROW_BITS(NARROW_BITS)) u_locate (
    .use_imm (loc_use_imm),
    .roff    (loc_roff),
    .imm     (loc_imm),
    .ea      (loc_ea),
    .wide    (loc_wide),
    .idx     (loc_idx),
    .addr    (loc_addr)
  );

  bmu_alter #(.DW(DW)) u_alter (
    .word     (alt_word),
    .idx      (alt_idx),
    .op       (alt_op),
    .new_word (alt_new),
    .old_bit  (alt_old)
  );

  bmu_ctrl #(.DW(DW), .AW(AW), .IMMW(IMMW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_mem     (cmd_mem),
    .cmd_imm     (cmd_imm),
    .cmd_wide    (cmd_wide),
    .cmd_reg_val (cmd_reg_val),
    .cmd_offset  (cmd_offset),
    .cmd_imm8    (cmd_imm8),
    .cmd_ea      (cmd_ea),
    .loc_use_imm (loc_use_imm),
    .loc_roff    (loc_roff),
    .loc_imm     (loc_imm),
    .loc_ea      (loc_ea),
    .loc_wide    (loc_wide),
    .loc_idx     (loc_idx),
    .loc_addr    (loc_addr),
    .alt_word    (alt_word),
    .alt_idx     (alt_idx),
    .alt_op      (alt_op),
    .alt_new     (alt_new),
    .alt_old     (alt_old),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_value   (res_value),
    .res_cf      (res_cf),
    .res_wr      (res_wr),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_rdy     (mem_rdy),
    .mem_lock    (mem_lock)
  );
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_value,
  input logic          res_cf,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rdy,
  input logic          mem_lock
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R7

  AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $stable(mem_addr) && $past(mem_rdy)); // R7

  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_lock); // R8

  AST_LOCK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> mem_req); // R8

  AST_LOCK_SPANS_RMW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock && mem_rdy && !mem_we |=> mem_lock && mem_we); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_value) && $stable(res_cf)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !res_valid && !mem_req); // R10
endmodule

bind bit_modify_unit bmu_checker #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/bit_modify_unit_test.sv
`timescale 1ns/1ps
module bit_modify_unit_test;
  typedef struct packed {
    logic [1:0]  op;
    logic        mem;
    logic        imm;
    logic        wide;
    logic [31:0] rv;
    logic [31:0] off;
    logic [7:0]  i8;
    logic [31:0] ea;
    logic [31:0] mword;
    logic [31:0] exp_val;
    logic        exp_cf;
    logic [31:0] exp_addr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b1, 32'h0000_0010, 32'h0000_0004, 8'h00, 32'h0, 32'h0, 32'h0000_0010, 1'b1, 32'h0},
    '{2'd1, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0025, 8'h00, 32'h0, 32'h0, 32'h0000_0020, 1'b0, 32'h0},
    '{2'd2, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'hFF, 32'h0, 32'h0, 32'h7FFF_FFFF, 1'b1, 32'h0},
    '{2'd3, 1'b0, 1'b1, 1'b1, 32'h0000_00F0, 32'h0000_0000, 8'h24, 32'h0, 32'h0, 32'h0000_00E0, 1'b1, 32'h0},
    '{2'd0, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0000_0045, 8'h00, 32'h0000_1000, 32'h0000_0020, 32'h0000_0020, 1'b1, 32'h0000_1008},
    '{2'd1, 1'b1, 1'b0, 1'b1, 32'h0, 32'hFFFF_FFE1, 8'h00, 32'h0000_1000, 32'h0000_0000, 32'h0000_0002, 1'b0, 32'h0000_0FFC},
    '{2'd2, 1'b1, 1'b1, 1'b1, 32'h0, 32'h0000_0000, 8'hE3, 32'h0000_2004, 32'h0000_00FF, 32'h0000_00F7, 1'b1, 32'h0000_2004},
    '{2'd3, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0000_0020, 8'h00, 32'h0001_FFFC, 32'h8000_0001, 32'h8000_0000, 1'b1, 32'h0000_0000},
    '{2'd3, 1'b1, 1'b0, 1'b1, 32'h0, 32'h8000_0000, 8'h00, 32'h1000_0000, 32'h0000_0000, 32'h0000_0001, 1'b0, 32'h0000_0000},
    '{2'd0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFE, 32'h0000_0020, 8'h00, 32'h0, 32'h0, 32'hFFFF_FFFE, 1'b0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic        cmd_mem = 1'b0;
  logic        cmd_imm = 1'b0;
  logic        cmd_wide = 1'b1;
  logic [31:0] cmd_reg_val = '0;
  logic [31:0] cmd_offset = '0;
  logic [7:0]  cmd_imm8 = '0;
  logic [31:0] cmd_ea = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_value;
  logic        res_cf;
  logic        res_wr;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_rdy;
  logic        mem_lock;

  logic [31:0] mem_word = '0;
  int          lat = 0;
  int          wait_cnt;
  int          rd_cnt, wr_cnt;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic        rd_lock, wr_lock;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bit_modify_unit uut (.*);

  assign mem_rdata = mem_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rdy  <= 1'b0;
      wait_cnt <= 0;
      rd_cnt   <= 0;
      wr_cnt   <= 0;
      rd_addr  <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_lock  <= 1'b0;
      wr_lock  <= 1'b0;
    end else if (mem_req && mem_rdy) begin
      mem_rdy  <= 1'b0;
      wait_cnt <= 0;
      if (mem_we) begin
        wr_cnt  <= wr_cnt + 1;
        wr_addr <= mem_addr;
        wr_data <= mem_wdata;
        wr_lock <= mem_lock;
      end else begin
        rd_cnt  <= rd_cnt + 1;
        rd_addr <= mem_addr;
        rd_lock <= mem_lock;
      end
    end else if (mem_req) begin
      if (wait_cnt >= lat) mem_rdy <= 1'b1;
      else wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    int cyc;
    int rd0, wr0;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(cmd_ready == 1'b1, "R11 cmd_ready", 32'(cmd_ready), 32'd1);
    chk(res_valid == 1'b0, "R11 res_valid", 32'(res_valid), 32'd0);
    chk(mem_req == 1'b0, "R11 mem_req", 32'(mem_req), 32'd0);
    chk(mem_lock == 1'b0, "R11 mem_lock", 32'(mem_lock), 32'd0);

    for (int i = 0; i < NV; i++) begin
      lat         = i % 3;
      mem_word    = VEC[i].mword;
      cmd_op      = VEC[i].op;
      cmd_mem     = VEC[i].mem;
      cmd_imm     = VEC[i].imm;
      cmd_wide    = VEC[i].wide;
      cmd_reg_val = VEC[i].rv;
      cmd_offset  = VEC[i].off;
      cmd_imm8    = VEC[i].i8;
      cmd_ea      = VEC[i].ea;
      rd0 = rd_cnt;
      wr0 = wr_cnt;
      chk(cmd_ready == 1'b1, "R10 ready when idle", 32'(cmd_ready), 32'd1);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc = 1;
      while (!res_valid && cyc < 200) begin
        @(negedge clk);
        cyc++;
      end
      // R1, R2, R3, R4, R5, R6 via expected value and carry
      chk(res_value == VEC[i].exp_val, "R2 value", res_value, VEC[i].exp_val);
      chk(res_cf == VEC[i].exp_cf, "R1 carry", 32'(res_cf), 32'(VEC[i].exp_cf));
      if (!VEC[i].mem) begin
        chk(cyc == 1, "R9 latency", 32'(cyc), 32'd1);
        chk(res_wr == (VEC[i].op != 2'd0), "R9 res_wr", 32'(res_wr), 32'(VEC[i].op != 2'd0));
        chk(rd_cnt == rd0 && wr_cnt == wr0, "R9 no memory", 32'(rd_cnt - rd0 + wr_cnt - wr0), 32'd0);
        chk(res_value == VEC[i].exp_val, "R3 register index", res_value, VEC[i].exp_val);
      end else begin
        chk(res_wr == 1'b0, "R9 res_wr memory", 32'(res_wr), 32'd0);
        chk(rd_cnt == rd0 + 1, "R7 one read", 32'(rd_cnt - rd0), 32'd1);
        chk(rd_addr == VEC[i].exp_addr, "R4 R5 R6 address", rd_addr, VEC[i].exp_addr);
        if (VEC[i].op == 2'd0) begin
          chk(wr_cnt == wr0, "R7 test no write", 32'(wr_cnt - wr0), 32'd0);
          chk(rd_lock == 1'b0, "R8 test unlocked", 32'(rd_lock), 32'd0);
        end else begin
          chk(wr_cnt == wr0 + 1, "R7 one write", 32'(wr_cnt - wr0), 32'd1);
          chk(wr_addr == VEC[i].exp_addr, "R7 write address", wr_addr, VEC[i].exp_addr);
          chk(wr_data == VEC[i].exp_val, "R2 write data", wr_data, VEC[i].exp_val);
          chk(rd_lock && wr_lock, "R8 lock over rmw", 32'({rd_lock, wr_lock}), 32'd3);
        end
      end
      @(negedge clk);
    end

    // R10: back-pressure on the result
    res_ready   = 1'b0;
    cmd_op      = 2'd3;
    cmd_mem     = 1'b0;
    cmd_imm     = 1'b1;
    cmd_imm8    = 8'h01;
    cmd_reg_val = 32'h0000_0000;
    cmd_valid   = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    held = res_value;
    chk(held == 32'h0000_0002, "R2 invert under stall", held, 32'h2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(res_valid == 1'b1, "R10 valid held", 32'(res_valid), 32'd1);
      chk(res_value == held, "R10 value held", res_value, held);
      chk(cmd_ready == 1'b0, "R10 busy while pending", 32'(cmd_ready), 32'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 drained", 32'(res_valid), 32'd0);
    chk(cmd_ready == 1'b1, "R10 ready again", 32'(cmd_ready), 32'd1);

    // R5: memory immediate with high bits set, large base; R6 narrow mask
    lat      = 2;
    mem_word = 32'h0000_0000;
    cmd_op   = 2'd1;
    cmd_mem  = 1'b1;
    cmd_imm  = 1'b1;
    cmd_wide = 1'b0;
    cmd_imm8 = 8'hFF;
    cmd_ea   = 32'h1234_5678;
    rd0 = rd_cnt;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (!res_valid && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(rd_addr == 32'h0000_5678, "R5 R6 no adjust masked", rd_addr, 32'h0000_5678);
    chk(res_value == 32'h8000_0000, "R5 index from imm low bits", res_value, 32'h8000_0000);
    chk(wr_data == 32'h8000_0000, "R7 written value", wr_data, 32'h8000_0000);
    @(negedge clk);
    finish_run();
  end
endmodule